// File: doc/BRIEF.md
# Flash Erase Range Sequencer

This block erases a byte range of a serial NOR flash, or the whole device, by producing the command words that a separate serial-interface controller shifts out. A range request carries a start address and a length in bytes. The block splits the range into a series of erase steps. For each step it uses the largest erase granule, 64 KB, 32 KB or 4 KB, that is aligned at the current address and that ends inside the range.

Every erase step uses the same command sequence. A write-enable command comes first, then the erase command. A status-read command follows. The block then asks the controller for status bytes one at a time until the busy bit reads zero. A no-operation command closes the streamed status read.

The time between status samples is a parameter counted in clock cycles. The number of busy samples allowed before the block gives up is also a parameter. A range whose start or end is not on a 4 KB boundary is rejected at once and issues no commands. When the operation ends, the block gives a one-cycle done pulse, with an error flag beside it when the operation failed.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `cmd_valid`, `sts_req`, `done`, `err_align` and `err_timeout` are all low.
- R2: If the start address or the end address (start plus length) of a range request is not a multiple of 4096, no command is issued. `done` and `err_align` pulse together in the cycle after the request.
- R3: Each erase step chooses its command in this order. Opcode 0xD8 (64 KB) is used when the current address is a multiple of 65536 and the address plus 65536 does not pass the end. Otherwise opcode 0x52 (32 KB) is used under the same test with 32768. Otherwise opcode 0x20 (4 KB) is used. The command address is the current address, and the current address then advances by the granule size.
- R4: Each erase command comes immediately after a write-enable command (opcode 0x06), with no other command between them.
- R5: After each erase command, the block issues one status-read command (opcode 0x05) and then pulses `sts_req` once for each status byte it wants. Bit 0 of `sts_byte` is the busy flag. The next step starts only after a sample with bit 0 equal to 0.
- R6: After a busy sample, the next `sts_req` pulse comes exactly GAP_CYCLES+1 cycles after the cycle in which that sample was valid.
- R7: If MAX_POLLS samples in a row show busy, the block sends the closing no-operation command and then pulses `done` with `err_timeout`. The remaining erase steps are dropped. When busy clears after MAX_POLLS-1 busy samples, there is no error.
- R8: Every status poll, whether it ends in success or in timeout, is closed by a no-operation command (opcode 0x00, address 0).
- R9: A whole-chip request sends write-enable, then opcode 0x60 with address 0, then the same status poll and closing command, and then pulses `done`.
- R10: A command word stays valid, with opcode and address unchanged, until it is accepted by `cmd_ready`.
- R11: `done` is a one-cycle pulse. The error flags are high only together with `done`. A zero-length aligned range issues no commands and pulses `done` with no error.
- R12: Requests that arrive while an operation is running are ignored. When a range request and a whole-chip request arrive in the same cycle, the range request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_req | input | 1 | Start a range erase (taken only while idle) |
| rng_start | input | ADDR_W | Range start address in bytes |
| rng_len | input | ADDR_W | Range length in bytes |
| chip_req | input | 1 | Start a whole-chip erase (taken only while idle) |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Controller accepts the command word |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address (0 for commands without an address) |
| sts_req | output | 1 | Request for one status byte |
| sts_valid | input | 1 | Status byte valid |
| sts_byte | input | 8 | Status byte; bit 0 is busy |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err_align | output | 1 | Range rejected as unaligned, valid with done |
| err_timeout | output | 1 | Busy did not clear, valid with done |

## Verification
The bench builds the block with GAP_CYCLES = 3 and MAX_POLLS = 4. With these values the spacing between polls can be measured cycle by cycle. They also make the timeout boundary reachable in a few dozen cycles: one busy sample fewer than the limit ends the step normally, and a run of busy samples equal to the limit ends the operation with an error. The address width stays at 24 bits, so ranges that mix all three granule sizes fit into short runs. Some runs use a controller that holds ready low on two cycles out of three, which exercises the hold rule of the command port.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_CHIP  = 8'h60;
  localparam logic [7:0] OP_ER64K = 8'hD8;

  // granule index 0 is the largest; smallest one is the alignment floor
  localparam int GRAN_N    = 3;
  localparam int MIN_SHIFT = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_ERASE, S_STS, S_PREQ, S_PWAIT, S_GAP, S_NOP, S_FIN
  } seq_st_e;

  function automatic int gran_shift(input int idx);
    case (idx)
      0:       return 16;
      1:       return 15;
      default: return MIN_SHIFT;
    endcase
  endfunction

  function automatic logic [7:0] gran_op(input int idx);
    case (idx)
      0:       return OP_ER64K;
      1:       return OP_ER32K;
      default: return OP_ER4K;
    endcase
  endfunction

endpackage

// File: rtl/fes_range_check.sv
module fes_range_check
  import fes_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] byte_len,
  output logic [ADDR_W:0]   end_addr,
  output logic              aligned
);

  always_comb begin
    end_addr = {1'b0, start_addr} + {1'b0, byte_len};
    aligned  = (start_addr[MIN_SHIFT-1:0] == '0) && (end_addr[MIN_SHIFT-1:0] == '0);
  end

endmodule

// File: rtl/fes_granule_pick.sv
module fes_granule_pick
  import fes_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W:0] cur_addr,
  input  logic [ADDR_W:0] lim_addr,
  output logic [7:0]      erase_op,
  output logic [ADDR_W:0] step_len
);

  localparam int SW = ADDR_W + 2;

  logic [GRAN_N-1:0] fits;

  for (genvar g = 0; g < GRAN_N; g++) begin : g_gran
    localparam int SH = gran_shift(g);
    logic [SW-1:0] reach;
    always_comb begin
      reach   = {1'b0, cur_addr} + (SW'(1) << SH);
      fits[g] = (cur_addr[SH-1:0] == '0) && (reach <= {1'b0, lim_addr});
    end
  end

  // walk from the smallest to the largest so the largest fitting one wins
  always_comb begin
    erase_op = OP_ER4K;
    step_len = (ADDR_W+1)'(1) << MIN_SHIFT;
    for (int g = GRAN_N - 1; g >= 0; g--) begin
      if (fits[g]) begin
        erase_op = gran_op(g);
        step_len = (ADDR_W+1)'(1) << gran_shift(g);
      end
    end
  end

endmodule

// File: rtl/fes_poll_ctr.sv
module fes_poll_ctr #(
  parameter int GAP_CYCLES = 25000,
  parameter int MAX_POLLS  = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_clr,
  input  logic busy_seen,
  input  logic gap_load,
  input  logic gap_run,
  output logic gap_expired,
  output logic last_poll
);

  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [GW-1:0] GAP_END  = GW'(GAP_CYCLES - 1);
  localparam logic [PW-1:0] POLL_END = PW'(MAX_POLLS - 1);

  logic [GW-1:0] gap_q, gap_d;
  logic          gap_en;
  logic [PW-1:0] poll_q, poll_d;
  logic          poll_en;

  always_comb begin
    gap_expired = (gap_q == GAP_END);
    last_poll   = (poll_q == POLL_END);
    gap_en      = gap_load || (gap_run && !gap_expired);
    gap_d       = gap_load ? '0 : gap_q + GW'(1);
    poll_en     = poll_clr || busy_seen;
    poll_d      = poll_clr ? '0 : poll_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      if (gap_en)  gap_q  <= gap_d;
      if (poll_en) poll_q <= poll_d;
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int GAP_CYCLES = 25000,
  parameter int MAX_POLLS  = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rng_req,
  input  logic [ADDR_W-1:0] rng_start,
  input  logic [ADDR_W-1:0] rng_len,
  input  logic              chip_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              sts_req,
  input  logic              sts_valid,
  input  logic [7:0]        sts_byte,
  output logic              done,
  output logic              err_align,
  output logic              err_timeout
);

  seq_st_e         state_q, state_d;
  logic [ADDR_W:0] cur_q, cur_d;
  logic [ADDR_W:0] lim_q, lim_d;
  logic            chip_q, chip_d;
  logic            tmo_q, tmo_d;
  logic            algn_q, algn_d;
  logic            ctx_en;

  logic [ADDR_W:0] req_end;
  logic            req_aligned;
  logic [7:0]      pick_op;
  logic [ADDR_W:0] pick_step;
  logic            poll_clr, busy_seen, gap_load, gap_run;
  logic            gap_expired, last_poll;

  fes_range_check #(.ADDR_W(ADDR_W)) u_rchk (
    .start_addr (rng_start),
    .byte_len   (rng_len),
    .end_addr   (req_end),
    .aligned    (req_aligned)
  );

  fes_granule_pick #(.ADDR_W(ADDR_W)) u_pick (
    .cur_addr (cur_q),
    .lim_addr (lim_q),
    .erase_op (pick_op),
    .step_len (pick_step)
  );

  fes_poll_ctr #(.GAP_CYCLES(GAP_CYCLES), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_clr    (poll_clr),
    .busy_seen   (busy_seen),
    .gap_load    (gap_load),
    .gap_run     (gap_run),
    .gap_expired (gap_expired),
    .last_poll   (last_poll)
  );

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    lim_d     = lim_q;
    chip_d    = chip_q;
    tmo_d     = tmo_q;
    algn_d    = algn_q;
    cmd_valid = 1'b0;
    cmd_op    = OP_NOP;
    cmd_addr  = '0;
    sts_req   = 1'b0;
    poll_clr  = 1'b0;
    busy_seen = 1'b0;
    gap_load  = 1'b0;
    gap_run   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (rng_req) begin
          cur_d  = {1'b0, rng_start};
          lim_d  = req_end;
          chip_d = 1'b0;
          tmo_d  = 1'b0;
          algn_d = !req_aligned;
          if (!req_aligned || (req_end == {1'b0, rng_start})) state_d = S_FIN;
          else                                                state_d = S_WREN;
        end else if (chip_req) begin
          chip_d  = 1'b1;
          tmo_d   = 1'b0;
          algn_d  = 1'b0;
          state_d = S_WREN;
        end
      end
      S_WREN: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WREN;
        if (cmd_ready) state_d = S_ERASE;
      end
      S_ERASE: begin
        cmd_valid = 1'b1;
        cmd_op    = chip_q ? OP_CHIP : pick_op;
        cmd_addr  = chip_q ? '0 : cur_q[ADDR_W-1:0];
        if (cmd_ready) begin
          if (!chip_q) cur_d = cur_q + pick_step;
          state_d = S_STS;
        end
      end
      S_STS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RDSR;
        if (cmd_ready) begin
          poll_clr = 1'b1;
          state_d  = S_PREQ;
        end
      end
      S_PREQ: begin
        sts_req = 1'b1;
        state_d = S_PWAIT;
      end
      S_PWAIT: begin
        if (sts_valid) begin
          if (!sts_byte[0]) begin
            state_d = S_NOP;
          end else begin
            busy_seen = 1'b1;
            if (last_poll) begin
              tmo_d   = 1'b1;
              state_d = S_NOP;
            end else begin
              gap_load = 1'b1;
              state_d  = S_GAP;
            end
          end
        end
      end
      S_GAP: begin
        gap_run = 1'b1;
        if (gap_expired) state_d = S_PREQ;
      end
      S_NOP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_NOP;
        if (cmd_ready) begin
          if (tmo_q || chip_q || (cur_q == lim_q)) state_d = S_FIN;
          else                                     state_d = S_WREN;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign ctx_en = (state_q == S_IDLE) || (state_q == S_ERASE) || (state_q == S_PWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      lim_q   <= '0;
      chip_q  <= 1'b0;
      tmo_q   <= 1'b0;
      algn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ctx_en) begin
        cur_q  <= cur_d;
        lim_q  <= lim_d;
        chip_q <= chip_d;
        tmo_q  <= tmo_d;
        algn_q <= algn_d;
      end
    end
  end

  always_comb begin
    done        = (state_q == S_FIN);
    err_align   = done && algn_q;
    err_timeout = done && tmo_q;
  end

endmodule

// File: rtl/fes_checker.sv
module fes_checker
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int GAP_CYCLES = 25000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              sts_req,
  input logic              sts_valid,
  input logic [7:0]        sts_byte,
  input logic              done,
  input logic              err_align,
  input logic              err_timeout
);

  localparam int CW = $clog2(GAP_CYCLES + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(GAP_CYCLES + 1);

  logic [7:0]    last_op;
  logic          busy_armed;
  logic [CW-1:0] since_busy;
  logic          hs;
  logic          is_erase;

  assign hs       = cmd_valid && cmd_ready;
  assign is_erase = (cmd_op == OP_ER4K) || (cmd_op == OP_ER32K) || (cmd_op == OP_ER64K) ||
                    (cmd_op == OP_CHIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op    <= OP_NOP;
      busy_armed <= 1'b0;
      since_busy <= '0;
    end else begin
      if (hs) last_op <= cmd_op;
      if (sts_valid && sts_byte[0]) begin
        busy_armed <= 1'b1;
        since_busy <= '0;
      end else if (since_busy != SAT) begin
        since_busy <= since_busy + CW'(1);
      end
    end
  end

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));

  p_wren_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && is_erase) |-> (last_op == OP_WREN));

  p_granule_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> !(((cmd_op == OP_ER4K)  && (cmd_addr[11:0] != '0)) ||
             ((cmd_op == OP_ER32K) && (cmd_addr[14:0] != '0)) ||
             ((cmd_op == OP_ER64K) && (cmd_addr[15:0] != '0))));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_align || err_timeout) |-> done);

  p_poll_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_req && busy_armed) |-> (since_busy >= CW'(GAP_CYCLES)));

  p_no_cmd_when_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

endmodule

bind flash_erase_seq fes_checker #(.ADDR_W(ADDR_W), .GAP_CYCLES(GAP_CYCLES)) u_fes_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_addr    (cmd_addr),
  .sts_req     (sts_req),
  .sts_valid   (sts_valid),
  .sts_byte    (sts_byte),
  .done        (done),
  .err_align   (err_align),
  .err_timeout (err_timeout)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;

  localparam int AW  = 24;
  localparam int GAP = 3;
  localparam int MXP = 4;

  typedef struct packed {
    logic [23:0] st;
    logic [23:0] ln;
    logic [3:0]  busy;
    logic        stall;
    logic [1:0]  err;   // 0 none, 1 alignment, 2 timeout
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 24'h010000, 4'd0, 1'b0, 2'd0},
    '{24'h001000, 24'h01F000, 4'd1, 1'b0, 2'd0},
    '{24'h018000, 24'h009000, 4'd2, 1'b1, 2'd0},
    '{24'h000800, 24'h001000, 4'd0, 1'b0, 2'd1},
    '{24'h002000, 24'h001800, 4'd0, 1'b0, 2'd1},
    '{24'h030000, 24'h002000, 4'd4, 1'b1, 2'd2},
    '{24'h005000, 24'h000000, 4'd0, 1'b0, 2'd0},
    '{24'h040000, 24'h008000, 4'd3, 1'b0, 2'd0}
  };

  logic          clk, rst_n;
  logic          rng_req, chip_req;
  logic [AW-1:0] rng_start, rng_len;
  logic          cmd_valid, cmd_ready;
  logic [7:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic          sts_req, sts_valid;
  logic [7:0]    sts_byte;
  logic          done, err_align, err_timeout;

  flash_erase_seq #(.ADDR_W(AW), .GAP_CYCLES(GAP), .MAX_POLLS(MXP)) i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .rng_req(rng_req), .rng_start(rng_start), .rng_len(rng_len),
    .chip_req(chip_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sts_req(sts_req), .sts_valid(sts_valid), .sts_byte(sts_byte),
    .done(done), .err_align(err_align), .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // controller model state
  int         busy_cfg = 0;
  logic       stall_cfg = 1'b0;
  int         busy_left = 0;
  int         tick = 0;
  logic [7:0] log_op [512];
  logic [23:0] log_ad [512];
  int         log_n = 0;
  int         sts_n = 0;
  int         done_n = 0;
  int         gap_bad = 0;
  int         gap_meas = 0;
  int         gap_dist = 0;
  logic       gap_arm = 1'b0;

  always @(posedge clk) begin
    tick <= tick + 1;
    cmd_ready <= stall_cfg ? ((tick % 3) == 0) : 1'b1;
    if (cmd_valid && cmd_ready) begin
      log_op[log_n] <= cmd_op;
      log_ad[log_n] <= cmd_addr;
      log_n <= log_n + 1;
      if (cmd_op == 8'h20 || cmd_op == 8'h52 || cmd_op == 8'hD8 || cmd_op == 8'h60)
        busy_left <= busy_cfg;
    end
    if (sts_req) begin
      sts_n     <= sts_n + 1;
      sts_valid <= 1'b1;
      sts_byte  <= {7'b0, busy_left != 0};
      if (busy_left != 0) busy_left <= busy_left - 1;
    end else begin
      sts_valid <= 1'b0;
      sts_byte  <= 8'hFE;
    end
  end

  always @(negedge clk) begin
    if (done) done_n <= done_n + 1;
    if (cmd_valid && cmd_op == 8'h06) gap_arm = 1'b0;
    if (sts_valid && sts_byte[0]) begin
      gap_arm  = 1'b1;
      gap_dist = 0;
    end else if (gap_arm) begin
      gap_dist = gap_dist + 1;
    end
    if (sts_req && gap_arm) begin
      if (gap_dist != GAP + 1) gap_bad <= gap_bad + 1;
      gap_meas <= gap_meas + 1;
      gap_arm = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected command list built from the requirements
  logic [7:0]  ex_op [128];
  logic [23:0] ex_ad [128];
  int          ex_n, ex_sts;

  task automatic push(input logic [7:0] op, input logic [23:0] ad);
    ex_op[ex_n] = op;
    ex_ad[ex_n] = ad;
    ex_n++;
  endtask

  task automatic build_range(input logic [23:0] st, input logic [23:0] ln, input int busy);
    longint cur, lim, sz;
    logic [7:0] op;
    ex_n = 0;
    ex_sts = 0;
    cur = st;
    lim = longint'(st) + longint'(ln);
    if ((cur % 4096) != 0 || (lim % 4096) != 0) return;
    while (cur < lim) begin
      if ((cur % 65536) == 0 && cur + 65536 <= lim)      begin op = 8'hD8; sz = 65536; end
      else if ((cur % 32768) == 0 && cur + 32768 <= lim) begin op = 8'h52; sz = 32768; end
      else                                               begin op = 8'h20; sz = 4096;  end
      push(8'h06, 24'h0);
      push(op, cur[23:0]);
      push(8'h05, 24'h0);
      push(8'h00, 24'h0);
      ex_sts += (busy >= MXP) ? MXP : busy + 1;
      if (busy >= MXP) break;
      cur += sz;
    end
  endtask

  task automatic build_chip(input int busy);
    ex_n = 0;
    push(8'h06, 24'h0);
    push(8'h60, 24'h0);
    push(8'h05, 24'h0);
    push(8'h00, 24'h0);
    ex_sts = (busy >= MXP) ? MXP : busy + 1;
  endtask

  // launch, wait for done, compare against the expected list
  task automatic run_op(input string tag, input logic do_rng, input logic do_chip,
                        input logic [23:0] st, input logic [23:0] ln, input int busy,
                        input logic stall, input int exp_err, input logic poke);
    int lb, sb, db, gb, gm, waited;
    logic got_done, ga, gt;
    busy_cfg  = busy;
    stall_cfg = stall;
    @(negedge clk);
    lb = log_n; sb = sts_n; db = done_n; gb = gap_bad; gm = gap_meas;
    rng_req = do_rng; chip_req = do_chip; rng_start = st; rng_len = ln;
    @(negedge clk);
    rng_req = 1'b0; chip_req = 1'b0;
    got_done = 1'b0; ga = 1'b0; gt = 1'b0;
    for (waited = 0; waited < 4000; waited++) begin
      if (done) begin
        got_done = 1'b1; ga = err_align; gt = err_timeout;
        break;
      end
      if (poke && waited == 4) begin
        rng_req = 1'b1; chip_req = 1'b1; rng_start = 24'h000800; rng_len = 24'h001000;
      end else begin
        rng_req = 1'b0; chip_req = 1'b0;
      end
      @(negedge clk);
    end
    rng_req = 1'b0; chip_req = 1'b0;
    chk(got_done, {tag, " R11 done seen"}, got_done, 1);
    chk(ga == (exp_err == 1), {tag, " R2 err_align"}, ga, exp_err == 1);
    chk(gt == (exp_err == 2), {tag, " R7 err_timeout"}, gt, exp_err == 2);
    repeat (12) @(negedge clk);
    chk(done_n - db == 1, {tag, " R11 R12 single done pulse"}, done_n - db, 1);
    chk(log_n - lb == ex_n, {tag, " R3 R8 command count"}, log_n - lb, ex_n);
    for (int i = 0; i < ex_n && i < log_n - lb; i++) begin
      chk(log_op[lb+i] == ex_op[i], $sformatf("%s R3 R4 R8 opcode #%0d", tag, i),
          log_op[lb+i], ex_op[i]);
      chk(log_ad[lb+i] == ex_ad[i], $sformatf("%s R3 address #%0d", tag, i),
          log_ad[lb+i], ex_ad[i]);
    end
    chk(sts_n - sb == ex_sts, {tag, " R5 status sample count"}, sts_n - sb, ex_sts);
    chk(gap_bad == gb, {tag, " R6 poll spacing"}, gap_bad - gb, 0);
    if (busy > 0 && ex_n > 0)
      chk(gap_meas > gm, {tag, " R6 spacing measured"}, gap_meas - gm, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rng_req = 1'b0; chip_req = 1'b0; rng_start = '0; rng_len = '0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid, "R1 cmd_valid in reset", cmd_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !sts_req, "R1 idle after reset", {cmd_valid, sts_req}, 0);
    chk(!done && !err_align && !err_timeout, "R1 flags after reset",
        {done, err_align, err_timeout}, 0);

    for (int v = 0; v < NV; v++) begin
      build_range(VECS[v].st, VECS[v].ln, int'(VECS[v].busy));
      run_op($sformatf("vec%0d", v), 1'b1, 1'b0, VECS[v].st, VECS[v].ln,
             int'(VECS[v].busy), VECS[v].stall, int'(VECS[v].err), 1'b0);
    end

    // R9 whole-chip erase
    build_chip(2);
    run_op("chip R9", 1'b0, 1'b1, 24'h0, 24'h0, 2, 1'b1, 0, 1'b0);

    // R9 whole-chip erase with timeout
    build_chip(MXP);
    run_op("chip-tmo R9 R7", 1'b0, 1'b1, 24'h0, 24'h0, MXP, 1'b0, 2, 1'b0);

    // R12 simultaneous requests: range wins
    build_range(24'h000000, 24'h001000, 1);
    run_op("both R12", 1'b1, 1'b1, 24'h000000, 24'h001000, 1, 1'b0, 0, 1'b0);

    // R12 requests while running are ignored
    build_range(24'h07E000, 24'h004000, 3);
    run_op("midrun R12", 1'b1, 1'b0, 24'h07E000, 24'h004000, 3, 1'b1, 0, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule